// File: doc/BRIEF.md
# Card Host Interrupt and DMA Request Router

This block holds the thirteen interrupt request flags of a memory-card host controller together with a matching mask register. It combines them into a single interrupt line for the processor and two request lines for a DMA engine. Other parts of the controller raise and drop individual flags through per-bit set and clear vectors. Software writes the mask, the DMA-mode control word and the card-clock start/stop command through simple write strobes.

In DMA mode the receive-FIFO and transmit-FIFO service flags no longer reach the processor interrupt. They drive the receive and transmit DMA request lines instead. The card-clock command keeps a clock-running status bit and owns the clock-off request flag: a stop raises the flag and a start drops it.

All outputs are derived without further registers from the stored flags, mask and mode. Any write therefore shows on the outputs after the clock edge that captures it.

Top module: `card_irq_router`

## Requirements
- R1: In reset the request flags read 0, the mask reads all ones (0x1FFF), DMA mode and clock-running are 0, and all three request outputs are low.
- R2: For every flag except bit 4, a 1 on `req_set` raises the flag and a 1 on `req_clr` drops it at the next clock edge; clear wins when both are given. Without either, the flag holds.
- R3: A mask write stores only the low 13 bits of `mask_wdata`. The upper data bits are discarded.
- R4: Outside DMA mode, `irq` is high exactly when some flag is set whose mask bit is 0.
- R5: A control write stores bit 7 of `ctrl_wdata` as the DMA-mode bit. While it is 1, flags 5 (receive FIFO) and 6 (transmit FIFO) are treated as masked for `irq`.
- R6: While DMA mode is 1, `dma_rx_req` equals flag 5 and `dma_tx_req` equals flag 6. While it is 0, both lines are low.
- R7: A clock command with bit 1 (start) set and bit 0 clear sets `clk_running` and clears flag 4 (clock off).
- R8: A clock command with bit 0 (stop) set clears `clk_running` and sets flag 4. Stop wins if both bits are set. `req_set[4]` and `req_clr[4]` have no effect on flag 4.
- R9: Mask, control and clock registers change only on a cycle with their write strobe. The outputs reflect a write after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 13 | Per-flag raise strobes |
| req_clr | input | 13 | Per-flag drop strobes |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | Mask write data |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word data, bit 7 is DMA mode |
| clkcmd_we | input | 1 | Clock command write strobe |
| clkcmd_wdata | input | 2 | Bit 1 start, bit 0 stop |
| req_flags | output | 13 | Current request flags |
| mask_flags | output | 13 | Current mask |
| clk_running | output | 1 | Card clock enabled status |
| irq | output | 1 | Processor interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume that every input is a defined 0 or 1 at each clock edge. They also assume that strobes and data are stable around the edge, so each strobe counts for exactly the one cycle it is sampled. The stimulus drives every input at a fixed offset after the rising edge and holds it through the next edge. It mixes sparse random set and clear vectors with random writes, including upper mask bits and both clock bits at once. It also tries bit-4 strobes that must be ignored and set-with-clear collisions.

// File: rtl/card_irq_router_pkg.sv
// Package card_irq_router_pkg
// Shared flag positions and sizes of the card host interrupt router.
// Assumes the thirteen-flag layout that the controller's other units decode.
package card_irq_router_pkg;
    localparam int unsigned NUM_FLAGS   = 13;
    localparam int unsigned WDATA_W     = 16;
    localparam int unsigned FLAG_CLKOFF = 4;
    localparam int unsigned FLAG_RXREQ  = 5;
    localparam int unsigned FLAG_TXREQ  = 6;
    localparam int unsigned DMA_MODE_BIT = 7;

    // decoded clock command for one cycle
    typedef struct packed {
        logic start;
        logic stop;
    } clk_cmd_t;
endpackage

// File: rtl/cir_clk_ctl.sv
// Module cir_clk_ctl
// Keeps the card-clock running status and turns a clock command into
// raise/drop pulses for the clock-off flag. Stop outranks start.
// Assumes the command is only meaningful in a cycle with cmd_we high.
module cir_clk_ctl
    import card_irq_router_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_we,
    input  clk_cmd_t cmd,
    output logic     running,
    output logic     off_raise,
    output logic     off_drop
);
    // decode the command into flag pulses, stop first
    always_comb begin
        off_raise = cmd_we && cmd.stop;
        off_drop  = cmd_we && cmd.start && !cmd.stop;
    end

    // running status follows the last effective command
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (off_raise) running <= 1'b0;
        else if (off_drop)  running <= 1'b1;
    end

    logic seen_cycle;
    // marks that one cycle out of reset has passed, for $past checks
    always_ff @(posedge clk) begin
        if (!rst_n) seen_cycle <= 1'b0;
        else        seen_cycle <= 1'b1;
    end

    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle && $past(cmd_we && cmd.stop) |-> !running);
    assert_start_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle && $past(cmd_we && cmd.start && !cmd.stop) |-> running);
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle && !$past(cmd_we) |-> $stable(running));
endmodule

// File: rtl/cir_req_reg.sv
// Module cir_req_reg
// Request flag register. Each ordinary flag has its own raise and drop
// strobe with drop winning. The flag at OWNED_BIT ignores the vectors and
// is driven only by the owner pulses.
module cir_req_reg #(
    parameter int unsigned NFLAGS    = 13,
    parameter int unsigned OWNED_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_v,
    input  logic [NFLAGS-1:0] clr_v,
    input  logic              own_raise,
    input  logic              own_drop,
    output logic [NFLAGS-1:0] flags
);
    localparam logic [NFLAGS-1:0] OWN_MASK = NFLAGS'(1) << OWNED_BIT;

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        if (i == OWNED_BIT) begin : g_owned
            // flag controlled only by the owner pulses
            always_ff @(posedge clk) begin
                if (!rst_n)         flags[i] <= 1'b0;
                else if (own_raise) flags[i] <= 1'b1;
                else if (own_drop)  flags[i] <= 1'b0;
            end
        end else begin : g_plain
            // ordinary flag, drop beats raise
            always_ff @(posedge clk) begin
                if (!rst_n)        flags[i] <= 1'b0;
                else if (clr_v[i]) flags[i] <= 1'b0;
                else if (set_v[i]) flags[i] <= 1'b1;
            end
        end
    end

    logic seen_cycle;
    // marks that one cycle out of reset has passed, for $past checks
    always_ff @(posedge clk) begin
        if (!rst_n) seen_cycle <= 1'b0;
        else        seen_cycle <= 1'b1;
    end

    assert_drop_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle |-> ((flags & $past(clr_v & ~OWN_MASK)) == '0));
    assert_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle |-> ((flags & $past(set_v & ~clr_v & ~OWN_MASK))
                        == $past(set_v & ~clr_v & ~OWN_MASK)));
    assert_owned_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle && $past(own_raise) |-> flags[OWNED_BIT]);
    assert_owned_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle && !$past(own_raise) && !$past(own_drop)
        |-> $stable(flags[OWNED_BIT]));
endmodule

// File: rtl/cir_route.sv
// Module cir_route
// Combines flags, mask and DMA mode into the processor interrupt and the
// two DMA request lines. In DMA mode the two FIFO flags join the mask and
// go to the DMA lines instead. Pure combinational logic.
module cir_route #(
    parameter int unsigned NFLAGS = 13,
    parameter int unsigned RX_BIT = 5,
    parameter int unsigned TX_BIT = 6
) (
    input  logic [NFLAGS-1:0] flags,
    input  logic [NFLAGS-1:0] mask,
    input  logic              dma_mode,
    output logic              irq,
    output logic              dma_rx,
    output logic              dma_tx
);
    localparam logic [NFLAGS-1:0] FIFO_MASK =
        (NFLAGS'(1) << RX_BIT) | (NFLAGS'(1) << TX_BIT);

    logic [NFLAGS-1:0] eff_mask;

    // widen the mask in DMA mode and steer the FIFO flags
    always_comb begin
        eff_mask = dma_mode ? (mask | FIFO_MASK) : mask;
        irq      = |(flags & ~eff_mask);
        dma_rx   = dma_mode && flags[RX_BIT];
        dma_tx   = dma_mode && flags[TX_BIT];
    end
endmodule

// File: rtl/card_irq_router.sv
// Module card_irq_router
// Top of the card host interrupt and DMA request router. Holds the mask and
// DMA-mode registers, and ties together the request flags, clock command
// and routing logic. Assumes write strobes are single-cycle qualified.
module card_irq_router
    import card_irq_router_pkg::*;
#(
    parameter int unsigned NFLAGS   = NUM_FLAGS,
    parameter int unsigned WR_W     = WDATA_W,
    parameter int unsigned DMA_BIT  = DMA_MODE_BIT,
    parameter int unsigned CLKOFF   = FLAG_CLKOFF,
    parameter int unsigned RXREQ    = FLAG_RXREQ,
    parameter int unsigned TXREQ    = FLAG_TXREQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] req_set,
    input  logic [NFLAGS-1:0] req_clr,
    input  logic              mask_we,
    input  logic [WR_W-1:0]   mask_wdata,
    input  logic              ctrl_we,
    input  logic [WR_W-1:0]   ctrl_wdata,
    input  logic              clkcmd_we,
    input  logic [1:0]        clkcmd_wdata,
    output logic [NFLAGS-1:0] req_flags,
    output logic [NFLAGS-1:0] mask_flags,
    output logic              clk_running,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    logic     dma_mode_q;
    logic     off_raise;
    logic     off_drop;
    clk_cmd_t cmd;

    // split the clock command into its two bits
    always_comb begin
        cmd.start = clkcmd_wdata[1];
        cmd.stop  = clkcmd_wdata[0];
    end

    // mask register keeps only the flag-wide low bits
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_flags <= '1;
        else if (mask_we) mask_flags <= mask_wdata[NFLAGS-1:0];
    end

    // DMA-mode bit captured from the control word
    always_ff @(posedge clk) begin
        if (!rst_n)       dma_mode_q <= 1'b0;
        else if (ctrl_we) dma_mode_q <= ctrl_wdata[DMA_BIT];
    end

    cir_clk_ctl u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (clkcmd_we),
        .cmd       (cmd),
        .running   (clk_running),
        .off_raise (off_raise),
        .off_drop  (off_drop)
    );

    cir_req_reg #(.NFLAGS(NFLAGS), .OWNED_BIT(CLKOFF)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_v     (req_set),
        .clr_v     (req_clr),
        .own_raise (off_raise),
        .own_drop  (off_drop),
        .flags     (req_flags)
    );

    cir_route #(.NFLAGS(NFLAGS), .RX_BIT(RXREQ), .TX_BIT(TXREQ)) u_route (
        .flags    (req_flags),
        .mask     (mask_flags),
        .dma_mode (dma_mode_q),
        .irq      (irq),
        .dma_rx   (dma_rx_req),
        .dma_tx   (dma_tx_req)
    );

    logic seen_cycle;
    // marks that one cycle out of reset has passed, for $past checks
    always_ff @(posedge clk) begin
        if (!rst_n) seen_cycle <= 1'b0;
        else        seen_cycle <= 1'b1;
    end

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle && !$past(mask_we) |-> $stable(mask_flags));
    assert_mask_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_cycle && $past(mask_we) |-> mask_flags == $past(mask_wdata[NFLAGS-1:0]));
    assert_dma_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode_q |-> !dma_rx_req && !dma_tx_req);
    assert_fifo_withheld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode_q && ((req_flags & ~mask_flags & ~((NFLAGS'(1) << RXREQ) |
        (NFLAGS'(1) << TXREQ))) == '0) |-> !irq);
    assert_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode_q && ((req_flags & ~mask_flags) != '0) |-> irq);
endmodule

// File: tb/sim_card_irq_router.sv
// Bench for card_irq_router: seeded random traffic plus directed corners,
// compared against a reference model kept in bench variables.
module sim_card_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] req_set = '0, req_clr = '0;
    logic        mask_we = 1'b0, ctrl_we = 1'b0, clkcmd_we = 1'b0;
    logic [15:0] mask_wdata = '0, ctrl_wdata = '0;
    logic [1:0]  clkcmd_wdata = '0;
    logic [12:0] req_flags, mask_flags;
    logic        clk_running, irq, dma_rx_req, dma_tx_req;

    int unsigned n_vec = 0, n_bad = 0;
    logic [12:0] m_req, m_mask;
    logic        m_dma, m_run;

    always #10 clk = ~clk;   // 50 MHz

    card_irq_router u0 (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .clkcmd_we(clkcmd_we), .clkcmd_wdata(clkcmd_wdata),
        .req_flags(req_flags), .mask_flags(mask_flags), .clk_running(clk_running),
        .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    function automatic logic exp_irq(logic [12:0] r, logic [12:0] m, logic d);
        logic [12:0] em = d ? (m | 13'h0060) : m;
        return |(r & ~em);
    endfunction

    task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R2/R8 flags"}, req_flags, m_req);
        chk({tag, " R3 mask"}, mask_flags, m_mask);
        chk({tag, " R7 clk_running"}, 13'(clk_running), 13'(m_run));
        chk({tag, " R4/R5 irq"}, 13'(irq), 13'(exp_irq(m_req, m_mask, m_dma)));
        chk({tag, " R6 dma_rx"}, 13'(dma_rx_req), 13'(m_dma & m_req[5]));
        chk({tag, " R6 dma_tx"}, 13'(dma_tx_req), 13'(m_dma & m_req[6]));
    endtask

    // one clock: model update at the edge, check 5 ns later, then idle inputs
    task automatic step(string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_req = '0; m_mask = '1; m_dma = 1'b0; m_run = 1'b0;
        end else begin
            for (int i = 0; i < 13; i++)
                if (i != 4) begin
                    if (req_clr[i]) m_req[i] = 1'b0;
                    else if (req_set[i]) m_req[i] = 1'b1;
                end
            if (clkcmd_we) begin
                if (clkcmd_wdata[0]) begin m_req[4] = 1'b1; m_run = 1'b0; end
                else if (clkcmd_wdata[1]) begin m_req[4] = 1'b0; m_run = 1'b1; end
            end
            if (mask_we) m_mask = mask_wdata[12:0];
            if (ctrl_we) m_dma = ctrl_wdata[7];
        end
        #5;
        check_all(tag);
        req_set = '0; req_clr = '0; mask_we = 0; ctrl_we = 0; clkcmd_we = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R1 reset state
        step("R1 reset"); step("R1 reset");
        #5 rst_n = 1'b1;
        // R2 set then clear-wins collision
        req_set = 13'h0103; step("R2 set");
        req_set = 13'h0001; req_clr = 13'h0001; step("R2 clr wins");
        // R8 bit 4 vector strobes ignored
        req_set = 13'h0010; step("R8 ignore set4");
        // R3 upper data bits dropped, R4 irq unmask
        mask_we = 1; mask_wdata = 16'hE000; step("R3 mask upper");
        // R7 start, R8 stop, both at once
        clkcmd_we = 1; clkcmd_wdata = 2'b10; step("R7 start");
        clkcmd_we = 1; clkcmd_wdata = 2'b11; step("R8 both stop wins");
        req_clr = 13'h0010; step("R8 ignore clr4");
        clkcmd_we = 1; clkcmd_wdata = 2'b10; step("R7 restart");
        // R5/R6 DMA steering with only FIFO flags pending
        req_clr = 13'h1FFF; step("R2 clear all");
        req_set = 13'h0060; ctrl_we = 1; ctrl_wdata = 16'h0080; step("R5 dma on");
        ctrl_we = 1; ctrl_wdata = 16'hFF7F; step("R6 dma off");
        // R9 held values without strobes
        mask_wdata = 16'h0000; ctrl_wdata = 16'h0080; step("R9 no strobe");
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            req_set = 13'($urandom) & 13'($urandom) & 13'($urandom);
            req_clr = 13'($urandom) & 13'($urandom) & 13'($urandom);
            mask_we = ($urandom % 6) == 0; mask_wdata = 16'($urandom);
            ctrl_we = ($urandom % 8) == 0; ctrl_wdata = 16'($urandom);
            clkcmd_we = ($urandom % 5) == 0; clkcmd_wdata = 2'($urandom);
            step("R2-rand R4 R5 R6 R7 R8");
        end
        // R1 reset again mid-run
        rst_n = 1'b0; step("R1 re-reset");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule